// File: doc/BRIEF.md
# Uncached Instruction Fetch Bypass

This block serves instruction fetches straight from a word-addressed memory bus, with no line storage in between. A fetch unit hands it a byte address. The block rounds that address down to the start of a fetch block. It then reads the words that make up the block one after another, in ascending address order, and packs them into a single wide response. The response carries an error flag, which is set whenever any of those reads came back with a bus error.

The request and the response are two separate valid/ready handshakes. The consumer may hold off taking the response for as long as it likes. Only one fetch is in flight at a time, so the request side stays closed from the moment a request is taken until its response has been consumed. A bus error ends the fetch at once: no more words are read, and the response is presented with its error flag set. In that case the data field carries no meaning.

Top module: `fetch_bypass`

## Requirements
- R1: After reset, req_ready is 1, while rsp_valid and bus_req are both 0.
- R2: The request address is aligned down to the fetch block. Its low log2(WORD_BYTES*BLOCK_WORDS) bits are ignored. The first bus read goes to word address (req_addr >> log2(WORD_BYTES)) with its low log2(BLOCK_WORDS) bits cleared.
- R3: The block issues BLOCK_WORDS reads to consecutive word addresses in ascending order, with one read outstanding at a time. bus_req and bus_adr stay steady until the read completes, which happens when bus_ack or bus_err is high at a rising edge.
- R4: The word read from block word k is placed in rsp_data[k*WORD_W +: WORD_W]. With the default 32-bit words and two words per block, the word at byte address A+4 sits in the upper 32 bits and the word at A sits in the lower 32 bits.
- R5: If a read ends with bus_err, the fetch stops. The next cycle has bus_req at 0 and rsp_valid at 1, with rsp_err at 1, and no further reads are issued for that request. A fetch with no bus error gives rsp_err = 0.
- R6: Once rsp_valid is 1, it stays 1 and rsp_data and rsp_err stay unchanged until rsp_ready is seen at a rising edge.
- R7: From the edge that accepts a request until its response is accepted, req_ready is 0. A req_valid asserted during that time starts no bus read and has no effect on the pending response.
- R8: In the cycle after a response is accepted, rsp_valid is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fetch request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Fetch byte address |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | WORD_W*BLOCK_WORDS | Assembled fetch block |
| rsp_err | output | 1 | A bus read of this block failed |
| bus_req | output | 1 | Bus read in progress |
| bus_adr | output | ADDR_W-log2(WORD_BYTES) | Bus word address |
| bus_ack | input | 1 | Read completed with data |
| bus_err | input | 1 | Read completed with an error |
| bus_rdata | input | WORD_W | Read data |

## Verification
The assertions rely on the bus side signalling completion only while bus_req is high. They also treat bus_err as taking priority over bus_ack whenever both are raised in the same cycle. The bench's bus model follows both rules: it raises ack or err only for a read it can see pending, and it never raises both at once. It also waits a programmable number of cycles before answering, so reads are held for varying lengths of time. The bench holds req_valid high with an unrelated address all the while a fetch is busy. This is legal on the request side and is there to show the block ignores it. req_valid is always dropped before rsp_ready is raised, so no second fetch slips in by accident.

// File: rtl/fb_pkg.sv
package fb_pkg;
  typedef enum logic [1:0] {
    FB_IDLE = 2'd0,
    FB_BUS  = 2'd1,
    FB_RESP = 2'd2
  } fb_state_e;
endpackage

// File: rtl/fb_ctrl.sv
module fb_ctrl
  import fb_pkg::*;
#(
  parameter int BLOCK_WORDS = 2,
  localparam int IDXW = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            bus_ack,
  input  logic            bus_err,
  input  logic            rsp_ready,
  output fb_state_e       state,
  output logic [IDXW-1:0] idx,
  output logic            err_seen
);
  localparam logic [IDXW-1:0] LAST = IDXW'(BLOCK_WORDS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= FB_IDLE;
      idx      <= '0;
      err_seen <= 1'b0;
    end else begin
      case (state)
        FB_IDLE: begin
          if (req_valid) begin
            state    <= FB_BUS;
            idx      <= '0;
            err_seen <= 1'b0;
          end
        end
        FB_BUS: begin
          if (bus_err) begin
            err_seen <= 1'b1;
            state    <= FB_RESP;
          end else if (bus_ack) begin
            if (idx == LAST) state <= FB_RESP;
            else             idx   <= idx + 1'b1;
          end
        end
        FB_RESP: begin
          if (rsp_ready) state <= FB_IDLE;
        end
        default: state <= FB_IDLE;
      endcase
    end
  end

  // R5: an error ends the walk over the block immediately
  p_err_ends_r5: assert property (@(posedge clk) disable iff (rst)
    (state == FB_BUS && bus_err) |=> (state == FB_RESP && err_seen));
endmodule

// File: rtl/fb_addr.sv
module fb_addr #(
  parameter int ADDR_W      = 32,
  parameter int WORD_BYTES  = 4,
  parameter int BLOCK_WORDS = 2,
  localparam int WSH  = $clog2(WORD_BYTES),
  localparam int BW   = ADDR_W - WSH,
  localparam int IDXW = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [IDXW-1:0] idx,
  output logic [BW-1:0]   word_adr
);
  localparam logic [BW-1:0] ALIGN_MASK = ~(BW'(BLOCK_WORDS - 1));

  logic [BW-1:0] base_q;
  logic          unused_low;

  assign unused_low = ^req_addr[WSH-1:0];

  always_ff @(posedge clk) begin
    if (rst)       base_q <= '0;
    else if (load) base_q <= req_addr[ADDR_W-1:WSH] & ALIGN_MASK;
  end

  assign word_adr = base_q | BW'(idx);

  // R2: the stored base never carries offset bits inside the block
  p_base_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> ((base_q & ~ALIGN_MASK) == '0));
endmodule

// File: rtl/fb_assemble.sv
module fb_assemble #(
  parameter int WORD_W      = 32,
  parameter int BLOCK_WORDS = 2,
  localparam int IDXW = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cap_en,
  input  logic [IDXW-1:0]               idx,
  input  logic [WORD_W-1:0]             rdata,
  output logic [WORD_W*BLOCK_WORDS-1:0] block
);
  for (genvar k = 0; k < BLOCK_WORDS; k++) begin : g_lane
    logic [WORD_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst)                                lane_q <= '0;
      else if (cap_en && idx == IDXW'(k))     lane_q <= rdata;
    end
    assign block[k*WORD_W +: WORD_W] = lane_q;
  end
endmodule

// File: rtl/fetch_bypass.sv
module fetch_bypass
  import fb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WORD_BYTES  = 4,
  parameter int BLOCK_WORDS = 2,
  localparam int WORD_W = 8 * WORD_BYTES,
  localparam int BW     = ADDR_W - $clog2(WORD_BYTES),
  localparam int IDXW   = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [ADDR_W-1:0]             req_addr,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [WORD_W*BLOCK_WORDS-1:0] rsp_data,
  output logic                          rsp_err,
  output logic                          bus_req,
  output logic [BW-1:0]                 bus_adr,
  input  logic                          bus_ack,
  input  logic                          bus_err,
  input  logic [WORD_W-1:0]             bus_rdata
);
  fb_state_e       state;
  logic [IDXW-1:0] idx;
  logic            load;
  logic            cap_en;

  assign req_ready = (state == FB_IDLE);
  assign rsp_valid = (state == FB_RESP);
  assign bus_req   = (state == FB_BUS);
  assign load      = req_ready && req_valid;
  assign cap_en    = bus_req && bus_ack && !bus_err;

  fb_ctrl #(.BLOCK_WORDS(BLOCK_WORDS)) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .bus_ack(bus_ack),
    .bus_err(bus_err), .rsp_ready(rsp_ready), .state(state), .idx(idx),
    .err_seen(rsp_err)
  );

  fb_addr #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .BLOCK_WORDS(BLOCK_WORDS)) u_addr (
    .clk(clk), .rst(rst), .load(load), .req_addr(req_addr), .idx(idx),
    .word_adr(bus_adr)
  );

  fb_assemble #(.WORD_W(WORD_W), .BLOCK_WORDS(BLOCK_WORDS)) u_asm (
    .clk(clk), .rst(rst), .cap_en(cap_en), .idx(idx), .rdata(bus_rdata),
    .block(rsp_data)
  );

  // R7: accepting a request closes the request side and starts a read
  p_accept_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && bus_req));

  // R2: every fetch starts at the first word of its block
  p_first_word_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> ((bus_adr & BW'(BLOCK_WORDS - 1)) == '0));

  // R3: a pending read keeps its address
  p_adr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack && !bus_err) |=> (bus_req && $stable(bus_adr)));

  // R5: a bus error yields an error response and no further reads
  p_err_rsp_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_err) |=> (!bus_req && rsp_valid && rsp_err));

  // R6: a waiting response does not change
  p_rsp_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));

  // R8: consuming the response reopens the request side
  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ready) |=> (req_ready && !rsp_valid));
endmodule

// File: tb/sim_fetch_bypass.sv
module sim_fetch_bypass;
  localparam int ADDR_W = 32;
  localparam int WB     = 4;
  localparam int BWDS   = 2;
  localparam int WW     = 8 * WB;
  localparam int BAW    = ADDR_W - 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b0;
  logic [WW*BWDS-1:0] rsp_data;
  logic rsp_err;
  logic bus_req;
  logic [BAW-1:0] bus_adr;
  logic bus_ack = 1'b0;
  logic bus_err = 1'b0;
  logic [WW-1:0] bus_rdata = '0;

  always #10 clk = ~clk;

  fetch_bypass #(.ADDR_W(ADDR_W), .WORD_BYTES(WB), .BLOCK_WORDS(BWDS)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .bus_req(bus_req), .bus_adr(bus_adr),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  // bus model state
  int            bus_dly  = 0;
  int            wait_cnt = 0;
  int            rd_cnt   = 0;
  int            err_k    = -1;
  logic [BAW-1:0] exp_base = '0;

  function automatic logic [WW-1:0] mem_word(input logic [BAW-1:0] a);
    return ({a, 2'b00} * 32'h9E37_79B1) ^ 32'h0F1E_2D3C;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // bus responder: answers on the falling edge, seen by the block at the next rising edge
  always @(negedge clk) begin
    logic busy_prev;
    busy_prev = bus_ack || bus_err;
    bus_ack = 1'b0;
    bus_err = 1'b0;
    if (bus_req && !busy_prev) begin
      if (wait_cnt >= bus_dly) begin
        wait_cnt = 0;
        // R3: consecutive ascending word addresses
        chk(bus_adr == exp_base + BAW'(rd_cnt), "R3 read address",
            64'(bus_adr), 64'(exp_base + BAW'(rd_cnt)));
        bus_rdata = mem_word(bus_adr);
        if (rd_cnt == err_k) bus_err = 1'b1;
        else                 bus_ack = 1'b1;
        rd_cnt++;
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic fetch(input logic [ADDR_W-1:0] a, input int dly, input int esel,
                       input int hold);
    logic [WW*BWDS-1:0] exp_data;
    logic [WW*BWDS-1:0] snap_d;
    logic               snap_e;
    int                 exp_rd;
    int                 guard;
    exp_base = a[ADDR_W-1:2] & ~BAW'(BWDS - 1);
    bus_dly  = dly;
    wait_cnt = 0;
    rd_cnt   = 0;
    err_k    = esel - 1;
    exp_rd   = (esel == 0) ? BWDS : esel;
    exp_data = {mem_word(exp_base + 1'b1), mem_word(exp_base)};
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_addr = ~a;  // R7: stray request while busy
    guard = 0;
    while (!rsp_valid && guard < 100) begin
      chk(!req_ready, "R7 closed while reading", 64'(req_ready), 64'd0);
      @(negedge clk);
      guard++;
    end
    chk(rsp_valid, "R3 response arrives", 64'(rsp_valid), 64'd1);
    chk(rsp_err == (esel != 0), "R5 error flag", 64'(rsp_err), 64'(esel != 0));
    if (esel == 0)
      chk(rsp_data == exp_data, "R4 block data", rsp_data, exp_data);
    snap_d = rsp_data;
    snap_e = rsp_err;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == snap_d && rsp_err == snap_e && !req_ready,
          "R6 response held", rsp_data, snap_d);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(req_ready && !rsp_valid, "R8 release", {62'd0, req_ready, rsp_valid}, 64'd2);
    chk(rd_cnt == exp_rd, "R5/R7 read count", 64'(rd_cnt), 64'(exp_rd));
    chk(!bus_req, "R7 no stray read", 64'(bus_req), 64'd0);
  endtask

  initial begin
    logic [ADDR_W-1:0] bases [4];
    bases[0] = 32'h0000_1000;
    bases[1] = 32'h00AB_CDE0;
    bases[2] = 32'hFFFF_FFF0;
    bases[3] = 32'h8000_0008;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !bus_req, "R1 reset state",
        {61'd0, req_ready, rsp_valid, bus_req}, 64'd4);
    for (int b = 0; b < 4; b++)
      for (int off = 0; off < 8; off++)      // R2: all offsets inside the block
        for (int d = 0; d < 3; d++)
          for (int e = 0; e < 3; e++)        // R5: no error, error on word 0, on word 1
            fetch(bases[b] + ADDR_W'(off), d, e, (off + e) % 3);
    finish_run();
  end
endmodule